// File: doc/BRIEF.md
# H-Bridge Drive Waveform Generator

This block produces the repeating gate pattern for a two-leg H-bridge that moves a small actuator. Each leg can be pulled high, pulled low or left floating. One drive cycle has eight phases. A push one way is followed by a brake, then a push the other way, then a second brake. A floating dead-time slot comes before each of these four phases. Every phase length is counted in base periods, and a small prescaler sets how many clocks make up one base period.

The block runs while `run` is high. It samples its whole configuration at the first clock of each cycle and keeps it until that cycle ends, so software can reprogram the fields at any moment without disturbing the phase in progress. It pulses `cycle_done` on the last clock of each cycle. It drives four separate gate enables, a high-side and a low-side enable for each leg.

Top module: `hbridge_wave_gen`

## Requirements
- R1: After reset, and whenever the sequencer is idle, all four gate enables and `cycle_done` are low.
- R2: A base period lasts `prescale`+1 clocks, so values 0 to 7 give 1 to 8 clocks. A length field of 0 behaves exactly like a field of 1.
- R3: One cycle lasts (F+1)+B1+R+B2 base periods, where F, B1, R and B2 are the four length fields after the zero rule. With F=0x13, B1=0x03, R=0x1E, B2=0x6B and `prescale`=0, the cycle is 160 clocks.
- R4: The phases run in a fixed order, and each length below is in base periods:
  - floating dead time, 1;
  - forward drive, F;
  - floating dead time, 1;
  - brake, B1-1;
  - floating dead time, 1;
  - reverse drive, R-1;
  - floating dead time, 1;
  - brake, B2-1.
  
  A phase of length zero is omitted. The order then repeats.
- R5: When `quick_dead` is 1 and `prescale` is non-zero, each dead-time slot lasts one clock, and the phase after it is lengthened by `prescale` clocks. Otherwise each dead-time slot lasts one base period.
- R6: When `brake_float` is 0, both legs are pulled low during the brake phases. When it is 1, both legs float during the brake phases.
- R7: With `swap_dir`=0, leg 1 is output A and leg 2 is output B. With `swap_dir`=1, the two are exchanged.
- R8: Forward drive pulls leg 1 high and leg 2 low. Reverse drive pulls leg 1 low and leg 2 high. A leg is high when only its high-side enable is set, low when only its low-side enable is set, and floating when neither is set.
- R9: The high-side and low-side enables of the same output are never set together.
- R10: All configuration inputs are sampled only at the first clock of a cycle. A change in the middle of a cycle affects only the next cycle.
- R11: `cycle_done` is high for exactly the last clock of each cycle.
- R12: `run` is sampled on each rising edge. The edge after which `run` is low stops the block, and from then on all outputs are low. When `run` rises again, a fresh cycle starts with the first dead-time slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Sequencer enable |
| fwd_len | input | 8 | Forward drive length field |
| brk1_len | input | 8 | First brake length field |
| rev_len | input | 8 | Reverse drive length field |
| brk2_len | input | 8 | Second brake length field |
| prescale | input | 3 | Base period select: clocks per period minus one |
| quick_dead | input | 1 | Dead time of one clock instead of one base period |
| brake_float | input | 1 | Brake phases float instead of pulling both legs low |
| swap_dir | input | 1 | Exchange legs 1 and 2 between outputs A and B |
| out_a_hi | output | 1 | Output A high-side enable |
| out_a_lo | output | 1 | Output A low-side enable |
| out_b_hi | output | 1 | Output B high-side enable |
| out_b_lo | output | 1 | Output B low-side enable |
| cycle_done | output | 1 | High on the last clock of each cycle |

## Verification
The bench targets several corner cases:
- Zero-valued fields collapse brake and reverse phases to nothing, so dead-time slots sit back to back. A sequencer that mishandles this would either stall for a clock or emit a spurious drive clock.
- Fast dead time with a non-zero prescale moves clocks from each slot into the following phase. A wrong split would change the cycle length, or leave a floating gap inside a brake.
- The one-clock-per-period case with fast dead time set is checked as well.
- A field is rewritten in the middle of a cycle, and a stop and restart is applied mid-phase. A design that took the new field at once would shorten the running cycle. One that resumed where it stopped would skip the opening dead time.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
    // Even encodings are the floating dead-time slots.
    typedef enum logic [2:0] {
        PH_DEAD0 = 3'd0,
        PH_FWD   = 3'd1,
        PH_DEAD1 = 3'd2,
        PH_BRK1  = 3'd3,
        PH_DEAD2 = 3'd4,
        PH_REV   = 3'd5,
        PH_DEAD3 = 3'd6,
        PH_BRK2  = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_e;
endpackage

// File: rtl/hbw_len.sv
module hbw_len
    import hbw_pkg::*;
#(
    parameter int FW = 8,
    parameter int OW = 3,
    parameter int LW = FW + OW + 1
) (
    input  logic [FW-1:0] fwd_len,
    input  logic [FW-1:0] brk1_len,
    input  logic [FW-1:0] rev_len,
    input  logic [FW-1:0] brk2_len,
    input  logic [OW-1:0] prescale,
    input  logic          quick_dead,
    input  phase_e        ph,
    output logic [LW-1:0] len
);
    logic [OW:0]   per;
    logic          fast;
    logic [FW-1:0] nper;
    logic [LW-1:0] ext;

    always_comb begin
        per  = (OW+1)'(prescale) + (OW+1)'(1);
        fast = quick_dead && (prescale != '0);
        ext  = fast ? (LW'(per) - LW'(1)) : '0;
        unique case (ph)
            PH_FWD:  nper = (fwd_len  == '0) ? FW'(1) : fwd_len;
            PH_BRK1: nper = (brk1_len == '0) ? '0 : brk1_len - FW'(1);
            PH_REV:  nper = (rev_len  == '0) ? '0 : rev_len  - FW'(1);
            PH_BRK2: nper = (brk2_len == '0) ? '0 : brk2_len - FW'(1);
            default: nper = '0;
        endcase
        if (!ph[0]) begin
            len = fast ? LW'(1) : LW'(per);
        end else begin
            len = LW'(nper) * LW'(per) + ext;
        end
    end
endmodule

// File: rtl/hbw_seq.sv
module hbw_seq
    import hbw_pkg::*;
#(
    parameter int FW = 8,
    parameter int OW = 3,
    parameter int LW = FW + OW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [FW-1:0] fwd_len,
    input  logic [FW-1:0] brk1_len,
    input  logic [FW-1:0] rev_len,
    input  logic [FW-1:0] brk2_len,
    input  logic [OW-1:0] prescale,
    input  logic          quick_dead,
    input  logic          brake_float,
    input  logic          swap_dir,
    output phase_e        ph,
    output logic          active,
    output logic          flt,
    output logic          swp,
    output logic          cycle_end
);
    typedef struct packed {
        logic          active;
        phase_e        ph;
        logic [LW-1:0] cnt;
        logic [FW-1:0] fwd;
        logic [FW-1:0] brk1;
        logic [FW-1:0] rev;
        logic [FW-1:0] brk2;
        logic [OW-1:0] psc;
        logic          qd;
        logic          flt;
        logic          swp;
    } seq_t;

    seq_t          s_d, s_q;
    phase_e        ph_n1, ph_n2;
    logic [LW-1:0] len_n1, len_n2, len_st;
    logic          last_ph;

    assign ph_n1 = phase_e'(s_q.ph + 3'd1);
    assign ph_n2 = phase_e'(s_q.ph + 3'd2);

    hbw_len #(.FW(FW), .OW(OW), .LW(LW)) u_len_n1 (
        .fwd_len(s_q.fwd), .brk1_len(s_q.brk1), .rev_len(s_q.rev), .brk2_len(s_q.brk2),
        .prescale(s_q.psc), .quick_dead(s_q.qd), .ph(ph_n1), .len(len_n1)
    );
    hbw_len #(.FW(FW), .OW(OW), .LW(LW)) u_len_n2 (
        .fwd_len(s_q.fwd), .brk1_len(s_q.brk1), .rev_len(s_q.rev), .brk2_len(s_q.brk2),
        .prescale(s_q.psc), .quick_dead(s_q.qd), .ph(ph_n2), .len(len_n2)
    );
    hbw_len #(.FW(FW), .OW(OW), .LW(LW)) u_len_st (
        .fwd_len(fwd_len), .brk1_len(brk1_len), .rev_len(rev_len), .brk2_len(brk2_len),
        .prescale(prescale), .quick_dead(quick_dead), .ph(PH_DEAD0), .len(len_st)
    );

    always_comb begin
        last_ph   = (s_q.ph == PH_BRK2) || ((s_q.ph == PH_DEAD3) && (len_n1 == '0));
        cycle_end = s_q.active && (s_q.cnt == '0) && last_ph;
        s_d       = s_q;
        if (!run) begin
            s_d.active = 1'b0;
            s_d.ph     = PH_DEAD0;
            s_d.cnt    = '0;
        end else if (!s_q.active || cycle_end) begin
            s_d.active = 1'b1;
            s_d.ph     = PH_DEAD0;
            s_d.cnt    = len_st - LW'(1);
            s_d.fwd    = fwd_len;
            s_d.brk1   = brk1_len;
            s_d.rev    = rev_len;
            s_d.brk2   = brk2_len;
            s_d.psc    = prescale;
            s_d.qd     = quick_dead;
            s_d.flt    = brake_float;
            s_d.swp    = swap_dir;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - LW'(1);
        end else if (len_n1 != '0) begin
            s_d.ph  = ph_n1;
            s_d.cnt = len_n1 - LW'(1);
        end else begin
            // an empty phase is always followed by a dead slot of non-zero length
            s_d.ph  = ph_n2;
            s_d.cnt = len_n2 - LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ph     = s_q.ph;
    assign active = s_q.active;
    assign flt    = s_q.flt;
    assign swp    = s_q.swp;

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && run && !cycle_end) |=>
            $stable({s_q.fwd, s_q.brk1, s_q.rev, s_q.brk2, s_q.psc, s_q.qd, s_q.flt, s_q.swp}));

    p_phase_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && run && (s_q.cnt != '0)) |=> $stable(s_q.ph));

    p_restart_dead_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !s_q.active) |=> (s_q.ph == PH_DEAD0));
endmodule

// File: rtl/hbw_outmap.sv
module hbw_outmap
    import hbw_pkg::*;
(
    input  logic       active,
    input  phase_e     ph,
    input  logic       flt,
    input  logic       swp,
    output logic [1:0] hi_en,
    output logic [1:0] lo_en
);
    leg_e leg1, leg2;
    leg_e legs [2];

    always_comb begin
        leg1 = LEG_OFF;
        leg2 = LEG_OFF;
        if (active) begin
            case (ph)
                PH_FWD: begin leg1 = LEG_HI; leg2 = LEG_LO; end
                PH_REV: begin leg1 = LEG_LO; leg2 = LEG_HI; end
                PH_BRK1, PH_BRK2: begin
                    if (!flt) begin leg1 = LEG_LO; leg2 = LEG_LO; end
                end
                default: ;
            endcase
        end
        legs[0] = swp ? leg2 : leg1;
        legs[1] = swp ? leg1 : leg2;
    end

    for (genvar g = 0; g < 2; g++) begin : g_leg
        assign hi_en[g] = (legs[g] == LEG_HI);
        assign lo_en[g] = (legs[g] == LEG_LO);
    end
endmodule

// File: rtl/hbridge_wave_gen.sv
module hbridge_wave_gen
    import hbw_pkg::*;
#(
    parameter int FW = 8,
    parameter int OW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [FW-1:0] fwd_len,
    input  logic [FW-1:0] brk1_len,
    input  logic [FW-1:0] rev_len,
    input  logic [FW-1:0] brk2_len,
    input  logic [OW-1:0] prescale,
    input  logic          quick_dead,
    input  logic          brake_float,
    input  logic          swap_dir,
    output logic          out_a_hi,
    output logic          out_a_lo,
    output logic          out_b_hi,
    output logic          out_b_lo,
    output logic          cycle_done
);
    localparam int LW = FW + OW + 1;

    phase_e     ph;
    logic       active, flt, swp;
    logic [1:0] hi_en, lo_en;

    hbw_seq #(.FW(FW), .OW(OW), .LW(LW)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run),
        .fwd_len(fwd_len), .brk1_len(brk1_len), .rev_len(rev_len), .brk2_len(brk2_len),
        .prescale(prescale), .quick_dead(quick_dead), .brake_float(brake_float),
        .swap_dir(swap_dir), .ph(ph), .active(active), .flt(flt), .swp(swp),
        .cycle_end(cycle_done)
    );

    hbw_outmap u_map (
        .active(active), .ph(ph), .flt(flt), .swp(swp), .hi_en(hi_en), .lo_en(lo_en)
    );

    assign out_a_hi = hi_en[0];
    assign out_a_lo = lo_en[0];
    assign out_b_hi = hi_en[1];
    assign out_b_lo = lo_en[1];

    p_no_short_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a_hi && out_a_lo));
    p_no_short_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_b_hi && out_b_lo));
    p_drive_pair_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_a_hi |-> out_b_lo);
    p_drive_pair_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_b_hi |-> out_a_lo);
    p_stop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(out_a_hi || out_a_lo || out_b_hi || out_b_lo || cycle_done));
    p_done_then_dead_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !(out_a_hi || out_a_lo || out_b_hi || out_b_lo));
endmodule

// File: tb/hbridge_wave_gen_test.sv
module hbridge_wave_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] ta = '0, b1 = '0, tb = '0, b2 = '0;
    logic [2:0] osc = '0;
    logic       hize = 1'b0, mode = 1'b0, dir = 1'b0;
    logic       a_hi, a_lo, b_hi, b_lo, done;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    string tag = "R1";

    logic [3:0] q[$];
    bit         m_run = 1'b0;
    int         gap_cnt = 0;
    int         last_gap = 0;

    always #2 clk = ~clk;

    hbridge_wave_gen uut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .fwd_len(ta), .brk1_len(b1), .rev_len(tb), .brk2_len(b2),
        .prescale(osc), .quick_dead(hize), .brake_float(mode), .swap_dir(dir),
        .out_a_hi(a_hi), .out_a_lo(a_lo), .out_b_hi(b_hi), .out_b_lo(b_lo),
        .cycle_done(done)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    function automatic void push_n(int count, logic [3:0] code);
        for (int i = 0; i < count; i++) q.push_back(code);
    endfunction

    // Expected per-clock codes {a_hi,a_lo,b_hi,b_lo} for one cycle from the current inputs
    function automatic void build_cycle();
        int         p, zl, ex;
        int         nf, n1, nr, n2;
        bit         fast;
        logic [3:0] cf, cr, cb;
        p    = int'(osc) + 1;
        fast = hize && (osc != 0);
        zl   = fast ? 1 : p;
        ex   = fast ? p - 1 : 0;
        nf   = (ta == 0) ? 1 : int'(ta);
        n1   = (b1 == 0) ? 0 : int'(b1) - 1;
        nr   = (tb == 0) ? 0 : int'(tb) - 1;
        n2   = (b2 == 0) ? 0 : int'(b2) - 1;
        cf   = dir ? 4'b0110 : 4'b1001;
        cr   = dir ? 4'b1001 : 4'b0110;
        cb   = mode ? 4'b0000 : 4'b0101;
        push_n(zl, 4'b0000); push_n(nf * p + ex, cf);
        push_n(zl, 4'b0000); push_n(n1 * p + ex, cb);
        push_n(zl, 4'b0000); push_n(nr * p + ex, cr);
        push_n(zl, 4'b0000); push_n(n2 * p + ex, cb);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 1'b0;
            q.delete();
        end else if (!run) begin
            m_run = 1'b0;
            q.delete();
        end else if (!m_run || q.size() <= 1) begin
            q.delete();
            build_cycle();
            m_run = 1'b1;
        end else begin
            void'(q.pop_front());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk({tag, " wave"}, int'({a_hi, a_lo, b_hi, b_lo}), m_run ? int'(q[0]) : 0);
            chk({tag, " R11 done"}, int'(done), int'(m_run && q.size() == 1));
            chk("R9 exclusive", int'((a_hi & a_lo) | (b_hi & b_lo)), 0);
            if (done) begin
                last_gap = gap_cnt;
                gap_cnt  = 1;
            end else begin
                gap_cnt++;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog: actual=hung expected=cycle progress");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R1 idle enables", int'({a_hi, a_lo, b_hi, b_lo}), 0);
        chk("R1 idle done", int'(done), 0);

        // worked example, short brake, no swap
        tag = "R3 R4 R6 R8";
        ta = 8'h13; b1 = 8'h03; tb = 8'h1E; b2 = 8'h6B; osc = 3'd0;
        hize = 1'b0; mode = 1'b0; dir = 1'b0;
        run = 1'b1;
        wait_done(); wait_done();
        chk("R3 cycle clocks", last_gap, 160);

        // mid-cycle rewrite: the running cycle keeps its length
        tag = "R10";
        tick(40);
        ta = 8'h40;
        wait_done();
        chk("R10 old cycle kept", last_gap, 160);
        wait_done();
        chk("R10 new cycle", last_gap, 205);

        // zero fields act as one, prescale of three clocks
        run = 1'b0;
        tick(2);
        chk("R12 stopped", int'({a_hi, a_lo, b_hi, b_lo, done}), 0);
        tag = "R2";
        ta = 8'h00; b1 = 8'h00; tb = 8'h00; b2 = 8'h00; osc = 3'd2;
        run = 1'b1;
        wait_done(); wait_done();
        chk("R2 zero fields", last_gap, 15);

        // fast dead time with floating brakes
        run = 1'b0;
        tick(1);
        tag = "R5 R6";
        hize = 1'b1; osc = 3'd3; mode = 1'b1;
        ta = 8'd2; b1 = 8'd3; tb = 8'd2; b2 = 8'd2;
        run = 1'b1;
        wait_done(); wait_done();
        chk("R5 fast dead cycle", last_gap, 40);
        mode = 1'b0;
        wait_done(); wait_done();
        chk("R6 short brake cycle", last_gap, 40);

        // fast dead time with a one-clock base period
        tag = "R5";
        osc = 3'd0; ta = 8'd1; b1 = 8'd1; tb = 8'd1; b2 = 8'd1;
        wait_done(); wait_done();
        chk("R5 unit period", last_gap, 5);

        // swapped legs
        tag = "R7 R8";
        hize = 1'b0; osc = 3'd1; dir = 1'b1;
        ta = 8'd3; b1 = 8'd2; tb = 8'd4; b2 = 8'd2;
        wait_done(); wait_done();
        chk("R7 swapped cycle", last_gap, 24);

        // stop mid-phase and restart from the first dead slot
        tag = "R12";
        tick(5);
        run = 1'b0;
        tick(1);
        chk("R12 stop mid-phase", int'({a_hi, a_lo, b_hi, b_lo, done}), 0);
        tick(3);
        run = 1'b1;
        tick(1);
        chk("R12 restart dead", int'({a_hi, a_lo, b_hi, b_lo}), 0);
        wait_done(); wait_done();
        chk("R12 restart cycle", last_gap, 24);

        run = 1'b0;
        tick(2);
        finish_run();
    end
endmodule